// File: doc/BRIEF.md
# VLIW Issue Word Assembler and Slot Decoder

This block turns a set of per-slot operation requests into one fixed-width VLIW issue word, and also turns such a word back into per-slot fields with an issue enable for each slot. Each request carries a presence flag, a 5-bit predicate code and an opaque 24-bit payload. The assembler builds the word in one registered stage. Every predicate field starts at the never-execute code. Fields of present slots are then replaced with the request's own values. A bundle with nothing in it is therefore a defined no-op word and never an all-zero word.

The decode side is combinational. It extracts the predicate and payload of each slot from any word presented to it. It raises an issue enable for a slot unless that slot's predicate turns it off. Code zero always issues. The never-execute code never issues. Every other code selects one entry of a 16-entry predicate register set and compares that entry with a polarity bit.

The assembler accepts one bundle per cycle through a valid/ready input and presents the packed word one cycle later with a valid strobe. All slots of one bundle leave together in the same word.

Top module: `vliw_bundle_unit`

## Requirements
- R1: While `rst` is high, `in_ready` and `out_valid` are low. After reset, `out_word` holds the empty bundle (R5 layout) and `in_ready` is high.
- R2: For slot i (0..6), the predicate field occupies bits 29*i to 29*i+4 (LSB-first). If slot i is absent from an accepted bundle, that field holds the never-execute code 5'b11111.
- R3: If slot i is present in an accepted bundle, bits 29*i to 29*i+4 hold its predicate and bits 29*i+5 to 29*i+28 hold its payload, whatever the code value (including 0 and 5'b11111).
- R4: The payload field of an absent slot is zero, and word bits 203 to 327 are always zero.
- R5: An accepted bundle with no slot present yields a nonzero word: 5'b11111 in all seven predicate fields and zero everywhere else.
- R6: A bundle accepted at a clock edge (`in_valid` and `in_ready` high) appears on `out_word` with `out_valid` high right after that edge. Bundles accepted on consecutive edges appear on consecutive cycles with no gap.
- R7: On an edge with no acceptance, `out_valid` goes low and `out_word` keeps its previous value, whatever the slot inputs carry.
- R8: The decoder's issue enable for a slot is low when that slot's predicate field is 5'b11111, regardless of `dec_pred_regs`.
- R9: The issue enable is high when the predicate field is 5'b00000, regardless of `dec_pred_regs`.
- R10: For any other code c, the issue enable equals (`dec_pred_regs[c[3:0]]` == c[4]).
- R11: The decoder outputs slot i's predicate on `dec_pred[5*i+4:5*i]` and its payload on `dec_payload[24*i+23:24*i]`, taken from the R2/R3 field positions of `dec_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A bundle request is offered |
| in_ready | output | 1 | The assembler can take a request this cycle |
| in_slot_valid | input | 7 | Presence flag per slot |
| in_slot_pred | input | 35 | Predicate code per slot, slot i at bits 5*i+4:5*i |
| in_slot_payload | input | 168 | Payload per slot, slot i at bits 24*i+23:24*i |
| out_valid | output | 1 | `out_word` holds a bundle accepted on the previous edge |
| out_word | output | 328 | Packed issue word |
| dec_word | input | 328 | Word to decode |
| dec_pred_regs | input | 16 | Predicate register values used by the decoder |
| dec_issue_en | output | 7 | Issue enable per slot |
| dec_pred | output | 35 | Decoded predicate per slot |
| dec_payload | output | 168 | Decoded payload per slot |

## Verification
The two functions that meet in one cycle are the default stamping of never-execute into every predicate field and the overwrite by a present slot. A slot that is present and whose own code is 5'b11111 collides with the default: it must come out with its payload written and its enable low. The same cycle also holds absent slots, which must keep the default code with a zero payload. The bench offers vectors with mixed presence masks, including all-present with the never-execute code, all-present with the always code, and all-absent. It compares each whole output word with an independently built expectation, then feeds the word back through the decoder and judges the enables against the predicate rules.

// File: rtl/vliw_bundle_pkg.sv
package vliw_bundle_pkg;

    localparam int PRED_W          = 5;
    localparam int PAYLOAD_W       = 24;
    localparam int PREG_SEL_W      = PRED_W - 1;
    localparam int PREG_COUNT      = 1 << PREG_SEL_W;
    localparam int DEF_BUNDLE_BITS = 328;
    localparam int DEF_SLOT_COUNT  = 7;
    localparam int DEF_SLOT_BASE   = 0;
    localparam int DEF_SLOT_STRIDE = PRED_W + PAYLOAD_W;
    localparam logic [PRED_W-1:0] DEF_NEVER_CODE  = 5'b11111;
    localparam logic [PRED_W-1:0] ALWAYS_CODE     = '0;

    typedef logic [PRED_W-1:0]    pred_code_t;
    typedef logic [PAYLOAD_W-1:0] payload_t;

    // One slot request as offered to the assembler
    typedef struct packed {
        logic       present;
        pred_code_t pred;
        payload_t   payload;
    } slot_req_t;

    // One slot as recovered from a packed word
    typedef struct packed {
        pred_code_t pred;
        payload_t   payload;
    } slot_field_t;

    // LSB-first bit position of a slot's predicate field
    function automatic int pred_lsb(input int base, input int stride, input int slot);
        return base + slot * stride;
    endfunction

    // LSB-first bit position of a slot's payload field (right above the predicate)
    function automatic int payload_lsb(input int base, input int stride, input int slot);
        return base + slot * stride + PRED_W;
    endfunction

endpackage

// File: rtl/bundle_packer.sv
module bundle_packer
    import vliw_bundle_pkg::*;
#(
    parameter int         BUNDLE_BITS = DEF_BUNDLE_BITS,
    parameter int         SLOT_COUNT  = DEF_SLOT_COUNT,
    parameter int         SLOT_BASE   = DEF_SLOT_BASE,
    parameter int         SLOT_STRIDE = DEF_SLOT_STRIDE,
    parameter pred_code_t NEVER_CODE  = DEF_NEVER_CODE
) (
    input  slot_req_t [SLOT_COUNT-1:0] req,
    output logic      [BUNDLE_BITS-1:0] word
);

    always_comb begin
        word = '0;
        for (int s = 0; s < SLOT_COUNT; s++) begin
            // default stamp first, so an absent slot is a defined no-op
            word[pred_lsb(SLOT_BASE, SLOT_STRIDE, s) +: PRED_W] = NEVER_CODE;
            if (req[s].present) begin
                word[pred_lsb(SLOT_BASE, SLOT_STRIDE, s) +: PRED_W]       = req[s].pred;
                word[payload_lsb(SLOT_BASE, SLOT_STRIDE, s) +: PAYLOAD_W] = req[s].payload;
            end
        end
    end

endmodule

// File: rtl/bundle_unpacker.sv
module bundle_unpacker
    import vliw_bundle_pkg::*;
#(
    parameter int BUNDLE_BITS = DEF_BUNDLE_BITS,
    parameter int SLOT_COUNT  = DEF_SLOT_COUNT,
    parameter int SLOT_BASE   = DEF_SLOT_BASE,
    parameter int SLOT_STRIDE = DEF_SLOT_STRIDE
) (
    input  logic        [BUNDLE_BITS-1:0] word,
    output slot_field_t [SLOT_COUNT-1:0]  fields
);

    always_comb begin
        for (int s = 0; s < SLOT_COUNT; s++) begin
            fields[s].pred    = word[pred_lsb(SLOT_BASE, SLOT_STRIDE, s) +: PRED_W];
            fields[s].payload = word[payload_lsb(SLOT_BASE, SLOT_STRIDE, s) +: PAYLOAD_W];
        end
    end

endmodule

// File: rtl/pred_eval.sv
module pred_eval
    import vliw_bundle_pkg::*;
#(
    parameter pred_code_t NEVER_CODE = DEF_NEVER_CODE
) (
    input  pred_code_t            code,
    input  logic [PREG_COUNT-1:0] pred_regs,
    output logic                  issue
);

    logic [PREG_SEL_W-1:0] sel;
    logic                  polarity;

    assign sel      = code[PREG_SEL_W-1:0];
    assign polarity = code[PRED_W-1];

    always_comb begin
        if (code == NEVER_CODE) begin
            issue = 1'b0;
        end else if (code == ALWAYS_CODE) begin
            issue = 1'b1;
        end else begin
            issue = (pred_regs[sel] == polarity);
        end
    end

endmodule

// File: rtl/vliw_bundle_unit.sv
module vliw_bundle_unit
    import vliw_bundle_pkg::*;
#(
    parameter int         BUNDLE_BITS = DEF_BUNDLE_BITS,
    parameter int         SLOT_COUNT  = DEF_SLOT_COUNT,
    parameter int         SLOT_BASE   = DEF_SLOT_BASE,
    parameter int         SLOT_STRIDE = DEF_SLOT_STRIDE,
    parameter pred_code_t NEVER_CODE  = DEF_NEVER_CODE
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              in_valid,
    output logic                              in_ready,
    input  logic [SLOT_COUNT-1:0]             in_slot_valid,
    input  logic [SLOT_COUNT*PRED_W-1:0]      in_slot_pred,
    input  logic [SLOT_COUNT*PAYLOAD_W-1:0]   in_slot_payload,
    output logic                              out_valid,
    output logic [BUNDLE_BITS-1:0]            out_word,
    input  logic [BUNDLE_BITS-1:0]            dec_word,
    input  logic [PREG_COUNT-1:0]             dec_pred_regs,
    output logic [SLOT_COUNT-1:0]             dec_issue_en,
    output logic [SLOT_COUNT*PRED_W-1:0]      dec_pred,
    output logic [SLOT_COUNT*PAYLOAD_W-1:0]   dec_payload
);

    slot_req_t   [SLOT_COUNT-1:0] req;
    slot_req_t   [SLOT_COUNT-1:0] no_req;
    slot_field_t [SLOT_COUNT-1:0] fields;
    logic        [BUNDLE_BITS-1:0] packed_word;
    logic        [BUNDLE_BITS-1:0] empty_word;
    logic                          accept;

    assign in_ready = !rst;
    assign accept   = in_valid && in_ready;
    assign no_req   = '0;

    generate
        for (genvar s = 0; s < SLOT_COUNT; s++) begin : g_req
            assign req[s].present = in_slot_valid[s];
            assign req[s].pred    = in_slot_pred[s*PRED_W +: PRED_W];
            assign req[s].payload = in_slot_payload[s*PAYLOAD_W +: PAYLOAD_W];
        end
    endgenerate

    bundle_packer #(
        .BUNDLE_BITS (BUNDLE_BITS),
        .SLOT_COUNT  (SLOT_COUNT),
        .SLOT_BASE   (SLOT_BASE),
        .SLOT_STRIDE (SLOT_STRIDE),
        .NEVER_CODE  (NEVER_CODE)
    ) live_pk (
        .req  (req),
        .word (packed_word)
    );

    // constant no-op word, used as the reset value of the output register
    bundle_packer #(
        .BUNDLE_BITS (BUNDLE_BITS),
        .SLOT_COUNT  (SLOT_COUNT),
        .SLOT_BASE   (SLOT_BASE),
        .SLOT_STRIDE (SLOT_STRIDE),
        .NEVER_CODE  (NEVER_CODE)
    ) empty_pk (
        .req  (no_req),
        .word (empty_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_word  <= empty_word;
        end else begin
            out_valid <= accept;
            if (accept) begin
                out_word <= packed_word;
            end
        end
    end

    bundle_unpacker #(
        .BUNDLE_BITS (BUNDLE_BITS),
        .SLOT_COUNT  (SLOT_COUNT),
        .SLOT_BASE   (SLOT_BASE),
        .SLOT_STRIDE (SLOT_STRIDE)
    ) dec_up (
        .word   (dec_word),
        .fields (fields)
    );

    generate
        for (genvar s = 0; s < SLOT_COUNT; s++) begin : g_dec
            assign dec_pred[s*PRED_W +: PRED_W]          = fields[s].pred;
            assign dec_payload[s*PAYLOAD_W +: PAYLOAD_W] = fields[s].payload;

            pred_eval #(
                .NEVER_CODE (NEVER_CODE)
            ) pe (
                .code      (fields[s].pred),
                .pred_regs (dec_pred_regs),
                .issue     (dec_issue_en[s])
            );
        end
    endgenerate

endmodule

// File: rtl/vliw_bundle_unit_chk.sv
module vliw_bundle_unit_chk
    import vliw_bundle_pkg::*;
#(
    parameter int         BUNDLE_BITS = DEF_BUNDLE_BITS,
    parameter int         SLOT_COUNT  = DEF_SLOT_COUNT,
    parameter int         SLOT_BASE   = DEF_SLOT_BASE,
    parameter int         SLOT_STRIDE = DEF_SLOT_STRIDE,
    parameter pred_code_t NEVER_CODE  = DEF_NEVER_CODE
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            in_valid,
    input logic                            in_ready,
    input logic [SLOT_COUNT-1:0]           in_slot_valid,
    input logic [SLOT_COUNT*PRED_W-1:0]    in_slot_pred,
    input logic                            out_valid,
    input logic [BUNDLE_BITS-1:0]          out_word,
    input logic [BUNDLE_BITS-1:0]          dec_word,
    input logic [PREG_COUNT-1:0]           dec_pred_regs,
    input logic [SLOT_COUNT-1:0]           dec_issue_en
);

    logic acc;
    assign acc = in_valid && in_ready;

    // R1
    reset_ready_chk: assert property (@(posedge clk) rst |-> !in_ready);

    // R6
    latency_chk: assert property (@(posedge clk) disable iff (rst) acc |=> out_valid);

    // R7
    idle_valid_chk: assert property (@(posedge clk) disable iff (rst) !acc |=> !out_valid);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst) !acc |=> $stable(out_word));

    // R10
    dec_pure_chk: assert property (@(posedge clk) disable iff (rst)
        ($stable(dec_word) && $stable(dec_pred_regs)) |-> $stable(dec_issue_en));

    generate
        for (genvar s = 0; s < SLOT_COUNT; s++) begin : g_slot
            localparam int PL = SLOT_BASE + s * SLOT_STRIDE;

            // R2
            absent_never_chk: assert property (@(posedge clk) disable iff (rst)
                (acc && !in_slot_valid[s]) |=> (out_word[PL +: PRED_W] == NEVER_CODE));

            // R3
            present_pred_chk: assert property (@(posedge clk) disable iff (rst)
                (acc && in_slot_valid[s]) |=>
                (out_word[PL +: PRED_W] == $past(in_slot_pred[s*PRED_W +: PRED_W])));

            // R8
            never_off_chk: assert property (@(posedge clk) disable iff (rst)
                (dec_word[PL +: PRED_W] == NEVER_CODE) |-> !dec_issue_en[s]);

            // R9
            always_on_chk: assert property (@(posedge clk) disable iff (rst)
                (dec_word[PL +: PRED_W] == ALWAYS_CODE) |-> dec_issue_en[s]);
        end
    endgenerate

endmodule

bind vliw_bundle_unit vliw_bundle_unit_chk #(
    .BUNDLE_BITS (BUNDLE_BITS),
    .SLOT_COUNT  (SLOT_COUNT),
    .SLOT_BASE   (SLOT_BASE),
    .SLOT_STRIDE (SLOT_STRIDE),
    .NEVER_CODE  (NEVER_CODE)
) chk_i (
    .clk           (clk),
    .rst           (rst),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .in_slot_valid (in_slot_valid),
    .in_slot_pred  (in_slot_pred),
    .out_valid     (out_valid),
    .out_word      (out_word),
    .dec_word      (dec_word),
    .dec_pred_regs (dec_pred_regs),
    .dec_issue_en  (dec_issue_en)
);

// File: tb/vliw_bundle_unit_tb_top.sv
`timescale 1ns/1ps
module vliw_bundle_unit_tb_top;

    localparam int NS = 7;
    localparam int PW = 5;
    localparam int YW = 24;
    localparam int WB = 328;
    localparam int ST = 29;
    localparam logic [4:0] NEVER = 5'b11111;

    typedef struct packed {
        logic [NS-1:0]    mask;
        logic [NS*PW-1:0] preds;
        logic [YW-1:0]    seed;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{7'h00, 35'h1_2345_6789, 24'hABCDEF},  // all empty
        '{7'h7F, 35'h0_0000_0000, 24'h123456},  // all full, always code
        '{7'h7F, 35'h7_FFFF_FFFF, 24'h0F0F0F},  // all full, never code
        '{7'h55, 35'h2_468A_CE13, 24'hFFFFFF},
        '{7'h2A, 35'h5_A5A5_A5A5, 24'h000000},
        '{7'h01, 35'h0_0000_0023, 24'h800001},
        '{7'h40, 35'h4_3210_FEDC, 24'h5A5A5A},
        '{7'h3C, 35'h3_1415_9265, 24'h271828}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [NS-1:0]     in_slot_valid = '0;
    logic [NS*PW-1:0]  in_slot_pred = '0;
    logic [NS*YW-1:0]  in_slot_payload = '0;
    logic              out_valid;
    logic [WB-1:0]     out_word;
    logic [WB-1:0]     dec_word = '0;
    logic [15:0]       dec_pred_regs = 16'hA5C3;
    logic [NS-1:0]     dec_issue_en;
    logic [NS*PW-1:0]  dec_pred;
    logic [NS*YW-1:0]  dec_payload;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    vliw_bundle_unit dut_i (
        .clk             (clk),
        .rst             (rst),
        .in_valid        (in_valid),
        .in_ready        (in_ready),
        .in_slot_valid   (in_slot_valid),
        .in_slot_pred    (in_slot_pred),
        .in_slot_payload (in_slot_payload),
        .out_valid       (out_valid),
        .out_word        (out_word),
        .dec_word        (dec_word),
        .dec_pred_regs   (dec_pred_regs),
        .dec_issue_en    (dec_issue_en),
        .dec_pred        (dec_pred),
        .dec_payload     (dec_payload)
    );

    function automatic logic [YW-1:0] slot_pay(input logic [YW-1:0] seed, input int s);
        return seed ^ (24'(s) * 24'h111111);
    endfunction

    function automatic logic [NS*YW-1:0] pays(input logic [YW-1:0] seed);
        logic [NS*YW-1:0] p;
        for (int s = 0; s < NS; s++) p[s*YW +: YW] = slot_pay(seed, s);
        return p;
    endfunction

    // expected word from the field layout of R2..R5
    function automatic logic [WB-1:0] build(input vec_t v);
        logic [WB-1:0] w = '0;
        for (int s = 0; s < NS; s++) begin
            w[s*ST +: PW] = v.mask[s] ? v.preds[s*PW +: PW] : NEVER;
            if (v.mask[s]) w[s*ST + PW +: YW] = slot_pay(v.seed, s);
        end
        return w;
    endfunction

    // issue rule of R8..R10
    function automatic logic exp_en(input logic [4:0] c, input logic [15:0] r);
        if (c == 5'b11111) return 1'b0;
        if (c == 5'b00000) return 1'b1;
        return r[c[3:0]] == c[4];
    endfunction

    function automatic string en_req(input logic [4:0] c);
        if (c == 5'b11111) return "R8";
        if (c == 5'b00000) return "R9";
        return "R10";
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [WB-1:0] act, input logic [WB-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        in_valid        = 1'b1;
        in_slot_valid   = v.mask;
        in_slot_pred    = v.preds;
        in_slot_payload = pays(v.seed);
    endtask

    // feed a word to the decoder and judge every slot
    task automatic check_decode(input logic [WB-1:0] w, input logic [15:0] regs);
        dec_word      = w;
        dec_pred_regs = regs;
        #0.5;
        for (int s = 0; s < NS; s++) begin
            logic [4:0] c = w[s*ST +: PW];
            chk(dec_issue_en[s] == exp_en(c, regs), en_req(c), $sformatf("issue slot %0d", s),
                WB'(dec_issue_en[s]), WB'(exp_en(c, regs)));
            chk(dec_pred[s*PW +: PW] == c, "R11", $sformatf("pred slot %0d", s),
                WB'(dec_pred[s*PW +: PW]), WB'(c));
            chk(dec_payload[s*YW +: YW] == w[s*ST + PW +: YW], "R11",
                $sformatf("payload slot %0d", s),
                WB'(dec_payload[s*YW +: YW]), WB'(w[s*ST + PW +: YW]));
        end
    endtask

    initial begin
        vec_t empty_v;
        logic [WB-1:0] last;
        logic [WB-1:0] w;
        empty_v = '{7'h00, 35'h0, 24'h0};

        // reset behaviour (R1)
        @(negedge clk);
        @(negedge clk);
        chk(!in_ready, "R1", "in_ready in reset", WB'(in_ready), '0);
        chk(!out_valid, "R1", "out_valid in reset", WB'(out_valid), '0);
        rst = 1'b0;
        #0.5;
        chk(in_ready, "R1", "in_ready after reset", WB'(in_ready), WB'(1));
        chk(out_word == build(empty_v), "R1", "word after reset", out_word, build(empty_v));
        @(negedge clk);

        // vector table, back to back (R2 R3 R4 R5 R6)
        last = '0;
        for (int k = 0; k < 8; k++) begin
            drive(VECS[k]);
            @(negedge clk);
            chk(out_valid, "R6", $sformatf("valid vec %0d", k), WB'(out_valid), WB'(1));
            chk(out_word == build(VECS[k]), "R3", $sformatf("word vec %0d", k),
                out_word, build(VECS[k]));
            chk(out_word[WB-1:NS*ST] == '0, "R4", $sformatf("spare bits vec %0d", k),
                WB'(out_word[WB-1:NS*ST]), '0);
            if (VECS[k].mask == '0) begin
                chk(out_word != '0, "R5", "empty bundle nonzero", out_word, build(VECS[k]));
                chk(out_word == build(VECS[k]), "R2", "empty bundle stamp", out_word, build(VECS[k]));
            end
            last = out_word;
            check_decode(out_word, 16'hA5C3);
        end

        // no acceptance: inputs change but word holds (R7)
        in_valid        = 1'b0;
        in_slot_valid   = 7'h7F;
        in_slot_pred    = 35'h0;
        in_slot_payload = pays(24'hC0FFEE);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(!out_valid, "R7", "valid low when idle", WB'(out_valid), '0);
            chk(out_word == last, "R7", "word held when idle", out_word, last);
        end

        // directed decode across code classes (R8 R9 R10)
        w = '0;
        w[0*ST +: PW] = 5'b11111;
        w[1*ST +: PW] = 5'b00000;
        w[2*ST +: PW] = 5'b00010;
        w[3*ST +: PW] = 5'b10010;
        w[4*ST +: PW] = 5'b10000;
        w[5*ST +: PW] = 5'b01111;
        w[6*ST +: PW] = 5'b11110;
        for (int s = 0; s < NS; s++) w[s*ST + PW +: YW] = slot_pay(24'h3C3C3C, s);
        check_decode(w, 16'h0005);
        check_decode(w, 16'hFFFA);
        check_decode(w, 16'h0000);
        check_decode(w, 16'hFFFF);

        // reset during an offered bundle (R1)
        @(negedge clk);
        drive(VECS[3]);
        rst = 1'b1;
        @(negedge clk);
        chk(!out_valid, "R1", "valid in mid reset", WB'(out_valid), '0);
        chk(out_word == build(empty_v), "R1", "word in mid reset", out_word, build(empty_v));
        in_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        chk(!out_valid, "R1", "valid after mid reset", WB'(out_valid), '0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule